// File: doc/BRIEF.md
# Audio System Clock Ratio Detector

This block works out, with no configuration input, how fast the converter's system clock runs relative to the audio sample rate. It counts system clock cycles between successive rising edges of a sample-rate strobe (a frame or word clock), snaps the count to one of six oversampling ratios and passes a 3-bit code to the interpolation filter and modulator logic. A valid flag tells that logic when the code can be trusted, and an unsupported flag tells it when the clock cannot be used.

A 2-bit sample-rate class input limits which ratios are allowed at high sample rates. The block stays silent for a fixed initialization window after the active-low reset is released or after the power-good input rises. It starts measuring only when that window ends. If the strobe stops, the block reports the clock as unusable instead of keeping a stale result.

Top module: `clk_ratio_detect`

## Requirements
- R1: The measured cycles-per-strobe-period is classified with no configuration input as one of six ratios, encoded on `ratio_o` as 0 = 128x, 1 = 192x, 2 = 256x, 3 = 384x, 4 = 512x, 5 = 768x.
- R2: A period matches a ratio when it is within plus or minus 2 cycles of it. A period outside every window sets `unsupported_o` and clears `valid_o`.
- R3: `valid_o` rises only on the second of two consecutive measurements that give the same supported code. It falls on the first measurement that gives a different code.
- R4: With `rate_class_i` = 1 (96 kHz), the 768x ratio is reported as unsupported. All the other ratios are accepted.
- R5: With `rate_class_i` = 2 (192 kHz), and also with the reserved value 3, only 128x and 192x are accepted. Any higher ratio is reported as unsupported.
- R6: After `rst_ni` is released with power good, the block waits 1024 system clock cycles before it accepts strobe edges. During that window `valid_o` and `unsupported_o` stay 0.
- R7: While `rst_ni` is low, `ratio_o`, `valid_o` and `unsupported_o` are 0.
- R8: If no strobe edge arrives, the period counter saturates at 1023. From then on `unsupported_o` is 1 and `valid_o` is 0. The first edge that follows still measures 1023 and so stays unsupported.
- R9: Low `pwr_good_i` clears all three outputs and restarts the 1024-cycle initialization once it returns high.
- R10: `valid_o` and `unsupported_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply-good level, synchronized inside |
| fs_strobe_i | input | 1 | Sample-rate strobe, one rising edge per sample period, asynchronous |
| rate_class_i | input | 2 | 0 = up to 48 kHz, 1 = 96 kHz, 2 = 192 kHz, 3 = treated as 192 kHz |
| ratio_o | output | 3 | Last accepted ratio code (R1 encoding) |
| valid_o | output | 1 | Code confirmed by two matching periods |
| unsupported_o | output | 1 | Clock ratio unusable at this rate or strobe lost |

## Verification
The bench moves across all six ratios and changes ratio mid-stream. A design that kept `valid_o` high across a change, or raised it after a single period, shows up as a mismatch. It places periods exactly at the edge of the tolerance window (plus 2) and just beyond it (plus 3), where an off-by-one window would accept or reject the wrong count. It applies 768x at 96 kHz and 256x at 192 kHz, which a design with no rate gating would report as valid. It stops the strobe long enough to saturate the counter, drops power-good in the middle of a run, and checks that nothing is reported before the 1024-cycle window ends, which catches a shortened or missing initialization.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int NUM_RATIOS = 6;
  localparam int CODE_W     = 3;

  typedef logic [CODE_W-1:0] ratio_code_t;

  typedef enum logic [1:0] {
    RATE_LOW  = 2'd0,
    RATE_MID  = 2'd1,
    RATE_HIGH = 2'd2,
    RATE_RSVD = 2'd3
  } rate_class_e;

  function automatic int unsigned ratio_of(int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      default: return 768;
    endcase
  endfunction

  // highest code allowed at a given sample-rate class
  function automatic ratio_code_t max_code(rate_class_e rc);
    case (rc)
      RATE_LOW: return ratio_code_t'(NUM_RATIOS - 1);
      RATE_MID: return ratio_code_t'(NUM_RATIOS - 2);
      default:  return ratio_code_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/crd_sync.sv
module crd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/crd_init_timer.sv
module crd_init_timer #(
  parameter int INIT_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic done_o
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!pwr_good_i)  cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/crd_period_counter.sv
module crd_period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             meas_vld_o,
  output logic             stall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_o     <= '0;
      meas_vld_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_vld_o <= 1'b0;
    end else begin
      meas_vld_o <= 1'b0;
      if (rise_i) begin
        // first edge after enable only arms the counter
        if (armed_q) begin
          meas_o     <= cnt_q;
          meas_vld_o <= 1'b1;
        end
        armed_q <= 1'b1;
        cnt_q   <= CNT_W'(1);
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign stall_o = armed_q && (cnt_q == '1);
endmodule

// File: rtl/crd_classifier.sv
module crd_classifier
  import crd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] meas_i,
  input  rate_class_e      rate_i,
  output ratio_code_t      code_o,
  output logic             ok_o
);
  logic [NUM_RATIOS-1:0] hit;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int unsigned LO = ratio_of(g) - TOL;
    localparam int unsigned HI = ratio_of(g) + TOL;
    assign hit[g] = (meas_i >= LO[CNT_W-1:0]) && (meas_i <= HI[CNT_W-1:0]);
  end

  always_comb begin
    code_o = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) code_o = ratio_code_t'(i);
    end
  end

  assign ok_o = (|hit) && (code_o <= max_code(rate_i));
endmodule

// File: rtl/crd_qualifier.sv
module crd_qualifier
  import crd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        meas_vld_i,
  input  ratio_code_t code_i,
  input  logic        ok_i,
  input  logic        stall_i,
  output ratio_code_t ratio_o,
  output logic        valid_o,
  output logic        unsup_o
);
  ratio_code_t prev_code_q;
  logic        prev_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o     <= '0;
      valid_o     <= 1'b0;
      unsup_o     <= 1'b0;
      prev_code_q <= '0;
      prev_ok_q   <= 1'b0;
    end else if (!en_i) begin
      ratio_o     <= '0;
      valid_o     <= 1'b0;
      unsup_o     <= 1'b0;
      prev_code_q <= '0;
      prev_ok_q   <= 1'b0;
    end else if (stall_i) begin
      valid_o   <= 1'b0;
      unsup_o   <= 1'b1;
      prev_ok_q <= 1'b0;
    end else if (meas_vld_i) begin
      if (ok_i) begin
        valid_o     <= prev_ok_q && (prev_code_q == code_i);
        unsup_o     <= 1'b0;
        ratio_o     <= code_i;
        prev_code_q <= code_i;
        prev_ok_q   <= 1'b1;
      end else begin
        valid_o   <= 1'b0;
        unsup_o   <= 1'b1;
        prev_ok_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import crd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 2,
  parameter int INIT_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       fs_strobe_i,
  input  logic [1:0] rate_class_i,
  output logic [2:0] ratio_o,
  output logic       valid_o,
  output logic       unsupported_o
);
  logic             pg_sync, fs_sync, fs_prev_q, fs_rise;
  logic             init_done, meas_vld, stall, cls_ok;
  logic [CNT_W-1:0] meas;
  ratio_code_t      cls_code;

  crd_sync #(.STAGES(SYNC_STAGES)) i_pg_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_good_i), .q_o(pg_sync)
  );

  crd_sync #(.STAGES(SYNC_STAGES)) i_fs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fs_strobe_i), .q_o(fs_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fs_prev_q <= 1'b0;
    else         fs_prev_q <= fs_sync;
  end

  assign fs_rise = fs_sync && !fs_prev_q;

  crd_init_timer #(.INIT_CYCLES(INIT_CYCLES)) i_init (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pg_sync), .done_o(init_done)
  );

  crd_period_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(init_done), .rise_i(fs_rise),
    .meas_o(meas), .meas_vld_o(meas_vld), .stall_o(stall)
  );

  crd_classifier #(.CNT_W(CNT_W), .TOL(TOL)) i_cls (
    .meas_i(meas), .rate_i(rate_class_e'(rate_class_i)),
    .code_o(cls_code), .ok_o(cls_ok)
  );

  crd_qualifier i_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(init_done), .meas_vld_i(meas_vld),
    .code_i(cls_code), .ok_i(cls_ok), .stall_i(stall),
    .ratio_o(ratio_o), .valid_o(valid_o), .unsup_o(unsupported_o)
  );
endmodule

// File: rtl/crd_checker.sv
module crd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       init_done,
  input logic       meas_vld,
  input logic       stall,
  input logic [1:0] rate_class_i,
  input logic [2:0] ratio_o,
  input logic       valid_o,
  input logic       unsupported_o
);
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ratio_o <= 3'd5);  // R1

  AST_VALID_ON_MEAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(meas_vld));  // R3

  AST_HIGH_RATE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(valid_o) && $past(rate_class_i[1])) |-> ratio_o <= 3'd1);  // R5

  AST_INIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done |=> (!valid_o && !unsupported_o));  // R6

  AST_STALL_UNSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done && stall) |=> (unsupported_o && !valid_o));  // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && unsupported_o));  // R10
endmodule

bind clk_ratio_detect crd_checker i_crd_checker (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .init_done(init_done),
  .meas_vld(meas_vld),
  .stall(stall),
  .rate_class_i(rate_class_i),
  .ratio_o(ratio_o),
  .valid_o(valid_o),
  .unsupported_o(unsupported_o)
);

// File: tb/test_clk_ratio_detect.sv
module test_clk_ratio_detect;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_good_i = 1'b0;
  logic       fs_strobe_i = 1'b0;
  logic [1:0] rate_class_i = 2'd0;
  logic [2:0] ratio_o;
  logic       valid_o;
  logic       unsupported_o;

  clk_ratio_detect i_clk_ratio_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .fs_strobe_i(fs_strobe_i), .rate_class_i(rate_class_i),
    .ratio_o(ratio_o), .valid_o(valid_o), .unsupported_o(unsupported_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic       valid;
    logic       unsup;
    logic [2:0] ratio;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  event item_ev;

  int n_checks = 0;
  int n_fail   = 0;
  bit reported = 0;

  // reference model state
  bit       sb_en = 0;
  bit       m_valid = 0, m_unsup = 0, m_prev_ok = 0;
  bit [2:0] m_ratio = 0, m_prev_code = 0;
  int       last_len = 0;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
    $finish;
  endtask

  function automatic int ratio_val(int i);
    case (i)
      0: return 128; 1: return 192; 2: return 256;
      3: return 384; 4: return 512; default: return 768;
    endcase
  endfunction

  // model one completed period of length gap
  task automatic model_step(int gap);
    int meas = (gap >= 1023) ? 1023 : gap;
    int code = -1;
    int lim;
    bit ok;
    for (int i = 0; i < 6; i++)
      if (meas >= ratio_val(i) - 2 && meas <= ratio_val(i) + 2) code = i;
    lim = (rate_class_i == 2'd0) ? 5 : (rate_class_i == 2'd1) ? 4 : 1;
    ok = (code >= 0) && (code <= lim);
    if (ok) begin
      m_valid = m_prev_ok && (m_prev_code == 3'(code));
      m_unsup = 0;
      m_ratio = 3'(code);
      m_prev_ok = 1;
      m_prev_code = 3'(code);
    end else begin
      m_valid = 0;
      m_unsup = 1;
      m_prev_ok = 0;
    end
  endtask

  // one strobe period of P cycles; rate change lands mid-period
  task automatic period(int p, int rate, string req);
    exp_t e;
    @(negedge clk_i);
    fs_strobe_i = 1'b1;
    if (sb_en) begin
      model_step(last_len);
      e.valid = m_valid; e.unsup = m_unsup; e.ratio = m_ratio; e.req = req;
      exp_q.push_back(e);
      ->item_ev;
    end
    last_len = p;
    repeat (p / 2 - 1) @(negedge clk_i);
    fs_strobe_i = 1'b0;
    rate_class_i = 2'(rate);
    repeat (p - p / 2) @(negedge clk_i);
  endtask

  task automatic periods(int p, int n, int rate, string req);
    for (int k = 0; k < n; k++) period(p, rate, req);
  endtask

  // monitor: outputs settle within 4 cycles of a strobe edge
  initial begin
    exp_t e;
    forever begin
      @(item_ev);
      repeat (6) @(negedge clk_i);
      e = exp_q.pop_front();
      check({e.req, " valid"}, valid_o, e.valid);
      check({e.req, " unsup"}, unsupported_o, e.unsup);
      check({e.req, " ratio"}, ratio_o, e.ratio);
      check("R10 exclusive", valid_o && unsupported_o, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    pwr_good_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R7 ratio in reset", ratio_o, 0);
    check("R7 valid in reset", valid_o, 0);
    check("R7 unsup in reset", unsupported_o, 0);
    rst_ni = 1'b1;

    // 256x from release; nothing may be reported inside the init window
    periods(256, 3, 0, "R6");
    repeat (232) @(negedge clk_i);
    check("R6 valid during init", valid_o, 0);
    check("R6 unsup during init", unsupported_o, 0);
    repeat (256 - 232 - 1) @(negedge clk_i);
    periods(256, 5, 0, "R6");
    check("R6 valid after init", valid_o, 1);
    check("R1 256x code", ratio_o, 2);
    m_valid = 1; m_unsup = 0; m_ratio = 2; m_prev_ok = 1; m_prev_code = 2;
    last_len = 256;
    sb_en = 1;

    periods(128, 3, 0, "R1 128x");
    periods(192, 1, 0, "R2 192x nominal");
    periods(194, 1, 0, "R2 192x +2");
    periods(190, 2, 0, "R2 192x -2");
    periods(384, 3, 0, "R1 384x");
    periods(512, 3, 0, "R1 512x");
    periods(768, 3, 0, "R1 768x");
    periods(300, 2, 0, "R2 off-grid");
    periods(131, 2, 0, "R2 +3 outside");
    periods(128, 3, 0, "R3 recover");
    periods(256, 1, 0, "R3 mismatch");
    periods(768, 3, 1, "R4 768x at 96k");
    periods(512, 3, 1, "R4 512x at 96k");
    periods(256, 3, 2, "R5 256x at 192k");
    periods(192, 3, 2, "R5 192x at 192k");
    periods(384, 2, 3, "R5 384x reserved");
    periods(128, 3, 3, "R5 128x reserved");

    // strobe stops: counter saturates
    repeat (1100) @(negedge clk_i);
    last_len += 1100;
    check("R8 unsup on stall", unsupported_o, 1);
    check("R8 valid on stall", valid_o, 0);
    m_valid = 0; m_unsup = 1; m_prev_ok = 0;
    periods(128, 4, 0, "R8 resume");

    // power-good drop clears outputs and restarts init
    @(negedge clk_i);
    pwr_good_i = 1'b0;
    sb_en = 0;
    repeat (4) @(negedge clk_i);
    check("R9 valid cleared", valid_o, 0);
    check("R9 unsup cleared", unsupported_o, 0);
    check("R9 ratio cleared", ratio_o, 0);
    pwr_good_i = 1'b1;
    periods(128, 7, 0, "R9");
    check("R9 no result inside re-init", valid_o, 0);
    periods(128, 6, 0, "R9");
    check("R9 valid after re-init", valid_o, 1);
    check("R9 128x code", ratio_o, 0);

    repeat (10) @(negedge clk_i);
    report();
  end
endmodule